// File: doc/BRIEF.md
# SPI Flash Identification Responder

This block acts as the target side of an SPI link and answers one request only: the identification query of a serial flash memory. A controller lowers chip select, clocks in one command byte on MOSI and then keeps clocking to read bytes back on MISO. When the command byte is the identification code, the responder returns a manufacturer code and two device code bytes. After those it returns a zero length byte, then zeros for as long as the clock runs. Any other command byte leaves MISO undriven for the rest of that selection.

The serial pins are oversampled by the block's own system clock. SCK, chip select and MOSI pass through a synchronizer of equal depth and then an edge detector. MOSI is captured on a rising SCK edge and MISO is updated on a falling SCK edge. Raising chip select at any moment discards the partial command and any response in progress. The next selection then starts again from the first command bit. The two device code bytes are parameters.

Top module: `spi_id_responder`

## Requirements
- R1: After reset, and whenever chip select (`cs_n`) is high, `miso_oe` is 0 and `miso` is 0.
- R2: The command byte is captured from `mosi` on eight rising `sck` edges, most-significant bit first. The identification command is the code 0x9F. MISO stays disabled while the command is being shifted in.
- R3: After a 0x9F command, the first falling `sck` edge that follows the eighth rising edge sets `miso_oe` to 1 and drives bit 7 of the first response byte. No dummy cycles come between the command and the response.
- R4: The response is a sequence of bytes, each sent most-significant bit first: 0x1F, then `DEV_ID_HI`, then `DEV_ID_LO`, then 0x00. One bit is sent per falling `sck` edge.
- R5: Once the fourth byte has been sent, every further falling `sck` edge drives 0 with `miso_oe` held at 1, for as long as chip select stays low.
- R6: A command byte other than 0x9F, even one that differs in a single bit, keeps `miso_oe` at 0 and `miso` at 0 until chip select rises, however many clocks follow.
- R7: Raising chip select during the command or during the response brings `miso_oe` to 0. The next selection decodes a new command from its first bit, and a 0x9F command returns the response from the start of the manufacturer byte.
- R8: `miso` and `miso_oe` change only as the result of a falling `sck` edge or of chip select rising. They hold steady across rising `sck` edges.
- R9: The second and third response bytes are exactly the values of the parameters `DEV_ID_HI` and `DEV_ID_LO`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Synchronous reset, active low |
| sck | input | 1 | SPI serial clock from the controller |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller; 0 while not enabled |
| miso_oe | output | 1 | MISO output enable; 0 means high impedance |

## Verification
A falling SCK edge reaches `miso` after the synchronizer depth plus one register, which is three system clocks at the default depth. A rise of chip select clears the output after the same delay. The bench holds each SCK phase for six system clocks, so every expected bit is due well before the next rising SCK edge. The driver queues the expected `{miso_oe, miso}` pair just before it raises SCK, and the monitor compares the pair at that rising edge. The monitor then compares it again two clocks later to confirm that the rising edge changed nothing. After each deselection the bench waits four clocks, more than the three-clock latency, before it checks that the output is disabled.

// File: rtl/spi_id_pkg.sv
// Shared definitions for the SPI identification responder.
// Assumes: one command byte per selection, response of fixed length.
package spi_id_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned ID_BYTES = 4;   // bytes before the zero tail

    typedef enum logic [1:0] {
        CMD_SHIFT  = 2'd0,
        CMD_MATCH  = 2'd1,
        CMD_IGNORE = 2'd2
    } cmd_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
// Brings sck, cs_n and mosi into the clk domain through STAGES flops
// each and flags sck edges.
// Assumes: sck phases last longer than STAGES+1 clk cycles. All three
// pins see the same delay, so mosi stays aligned with the detected edge.
module spi_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_hi,
    output logic mosi_s
);
    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] mosi_p;
    logic              sck_prev;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // first flop of each pin samples the raw input
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sck_p[0]  <= 1'b0;
                    cs_p[0]   <= 1'b1;
                    mosi_p[0] <= 1'b0;
                end else begin
                    sck_p[0]  <= sck;
                    cs_p[0]   <= cs_n;
                    mosi_p[0] <= mosi;
                end
            end
        end else begin : g_next
            // later flops pass the previous stage along
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sck_p[g]  <= 1'b0;
                    cs_p[g]   <= 1'b1;
                    mosi_p[g] <= 1'b0;
                end else begin
                    sck_p[g]  <= sck_p[g-1];
                    cs_p[g]   <= cs_p[g-1];
                    mosi_p[g] <= mosi_p[g-1];
                end
            end
        end
    end

    // remember last synchronized sck level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_p[STAGES-1];
    end

    assign sck_rise = sck_p[STAGES-1] & ~sck_prev;
    assign sck_fall = ~sck_p[STAGES-1] & sck_prev;
    assign cs_hi    = cs_p[STAGES-1];
    assign mosi_s   = mosi_p[STAGES-1];
endmodule

// File: rtl/spi_cmd_shifter.sv
// Collects the command byte MSB first on sck rising edges and decides,
// on the eighth bit, whether it is the identification code.
// Assumes: cs_hi clears all state; bits after the eighth are ignored.
module spi_cmd_shifter
    import spi_id_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CMD_CODE = 8'h9F
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_rise,
    input  logic cs_hi,
    input  logic mosi_s,
    output logic matched
);
    localparam int unsigned CNT_W = $clog2(BYTE_W);

    cmd_state_e        state;
    logic [BYTE_W-2:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] full_byte;

    assign full_byte = {shreg, mosi_s};

    // shift command bits in and classify the completed byte
    always_ff @(posedge clk) begin
        if (!rst_n || cs_hi) begin
            state   <= CMD_SHIFT;
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (sck_rise && state == CMD_SHIFT) begin
            shreg   <= full_byte[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(BYTE_W - 1))
                state <= (full_byte == CMD_CODE) ? CMD_MATCH : CMD_IGNORE;
        end
    end

    assign matched = (state == CMD_MATCH);

    // R2: a decision is only ever taken on a rising sck edge
    p_match_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(matched) |-> $past(sck_rise));

    // R6: a rejected command stays rejected until deselection
    p_ignore_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CMD_IGNORE && !cs_hi) |=> state == CMD_IGNORE);
endmodule

// File: rtl/spi_id_serializer.sv
// Sends the identification bytes MSB first, one bit per sck falling
// edge, once the command shifter reports a match; zeros follow the
// last identification byte.
// Assumes: matched and cs_hi come from the same synchronized domain.
module spi_id_serializer
    import spi_id_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MFR_CODE  = 8'h1F,
    parameter logic [BYTE_W-1:0] DEV_ID_HI = 8'h00,
    parameter logic [BYTE_W-1:0] DEV_ID_LO = 8'h00
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_fall,
    input  logic cs_hi,
    input  logic matched,
    output logic miso,
    output logic miso_oe
);
    localparam int unsigned BIT_W  = $clog2(BYTE_W);
    localparam int unsigned IDX_W  = $clog2(ID_BYTES + 1);
    localparam logic [IDX_W-1:0] TAIL_IDX = IDX_W'(ID_BYTES);

    logic [IDX_W-1:0]  byte_idx;
    logic [BIT_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] cur_byte;
    logic              miso_q;
    logic              oe_q;

    // pick the byte currently being sent; the tail is all zeros
    always_comb begin
        case (byte_idx)
            IDX_W'(0): cur_byte = MFR_CODE;
            IDX_W'(1): cur_byte = DEV_ID_HI;
            IDX_W'(2): cur_byte = DEV_ID_LO;
            default:   cur_byte = '0;
        endcase
    end

    // drive one bit per falling edge and step through the bytes
    always_ff @(posedge clk) begin
        if (!rst_n || cs_hi) begin
            byte_idx <= '0;
            bit_idx  <= BIT_W'(BYTE_W - 1);
            miso_q   <= 1'b0;
            oe_q     <= 1'b0;
        end else if (matched && sck_fall) begin
            miso_q  <= cur_byte[bit_idx];
            oe_q    <= 1'b1;
            bit_idx <= bit_idx - 1'b1;
            if (bit_idx == '0 && byte_idx != TAIL_IDX)
                byte_idx <= byte_idx + 1'b1;
        end
    end

    assign miso    = miso_q;
    assign miso_oe = oe_q;

    // R1/R7: deselection disables the output on the next cycle
    p_oe_off_deselected_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !oe_q && !miso_q);

    // R6: output is enabled only under a recognised command
    p_oe_needs_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> matched);

    // R8: without a falling edge or deselection the output holds
    p_miso_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !cs_hi) |=> $stable(miso_q) && $stable(oe_q));

    // R5: once in the zero tail the index stays there
    p_tail_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_idx == TAIL_IDX && !cs_hi) |=> byte_idx == TAIL_IDX);
endmodule

// File: rtl/spi_id_responder.sv
// Top level of the SPI identification responder: synchronizes the pins,
// decodes the command byte and serializes the identification reply.
// Assumes: clk is at least (SYNC_STAGES+2) times faster per sck phase.
module spi_id_responder
    import spi_id_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CMD_CODE    = 8'h9F,
    parameter logic [BYTE_W-1:0] MFR_CODE    = 8'h1F,
    parameter logic [BYTE_W-1:0] DEV_ID_HI   = 8'h00,
    parameter logic [BYTE_W-1:0] DEV_ID_LO   = 8'h00,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);
    logic sck_rise;
    logic sck_fall;
    logic cs_hi;
    logic mosi_s;
    logic matched;

    spi_pin_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_hi    (cs_hi),
        .mosi_s   (mosi_s)
    );

    spi_cmd_shifter #(
        .CMD_CODE(CMD_CODE)
    ) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .cs_hi    (cs_hi),
        .mosi_s   (mosi_s),
        .matched  (matched)
    );

    spi_id_serializer #(
        .MFR_CODE  (MFR_CODE),
        .DEV_ID_HI (DEV_ID_HI),
        .DEV_ID_LO (DEV_ID_LO)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_fall (sck_fall),
        .cs_hi    (cs_hi),
        .matched  (matched),
        .miso     (miso),
        .miso_oe  (miso_oe)
    );
endmodule

// File: tb/spi_id_responder_tb_top.sv
// Scoreboard bench: the driver queues the expected {oe, miso} pair
// before each rising sck, and the monitor compares it at that edge.
module spi_id_responder_tb_top;
    localparam logic [7:0] DEV_HI = 8'hA5;
    localparam logic [7:0] DEV_LO = 8'h3C;
    localparam int         H      = 6;       // clk cycles per sck phase

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck_r = 1'b0;
    logic cs_n_r = 1'b1;
    logic mosi_r = 1'b0;
    logic miso;
    logic miso_oe;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    spi_id_responder #(
        .DEV_ID_HI (DEV_HI),
        .DEV_ID_LO (DEV_LO)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (sck_r),
        .cs_n    (cs_n_r),
        .mosi    (mosi_r),
        .miso    (miso),
        .miso_oe (miso_oe)
    );

    function automatic logic [7:0] exp_byte(input int b);
        case (b)
            0:       return 8'h1F;
            1:       return DEV_HI;
            2:       return DEV_LO;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {oe,miso} actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // monitor: compare at each rising sck, then confirm the rise changed nothing
    always @(posedge sck_r) begin
        logic [1:0] e;
        logic [1:0] seen;
        string      t;
        if (exp_q.size() > 0) begin
            e    = exp_q.pop_front();
            t    = tag_q.pop_front();
            seen = {miso_oe, miso};
            check(seen, e, t);
            repeat (2) @(negedge clk);
            check({miso_oe, miso}, seen, "R8");
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one selection: cmd_bits command bits, then rsp_bits response bits
    task automatic xfer(input logic [7:0] cmd, input int cmd_bits, input bit hit,
                        input int rsp_bits, input string tag);
        cs_n_r = 1'b0;
        for (int i = 0; i < cmd_bits; i++) begin
            mosi_r = cmd[7 - i];
            wait_clk(H);
            exp_q.push_back(2'b00);
            tag_q.push_back("R2");
            sck_r = 1'b1;
            wait_clk(H);
            sck_r = 1'b0;
        end
        mosi_r = 1'b0;
        for (int n = 0; n < rsp_bits; n++) begin
            int       b = n / 8;
            int       k = 7 - (n % 8);
            logic [7:0] v = exp_byte(b);
            string    t;
            if (tag != "")   t = tag;
            else if (!hit)   t = "R6";
            else if (b == 0) t = "R3";
            else if (b < 3)  t = "R4 R9";
            else if (b == 3) t = "R4";
            else             t = "R5";
            wait_clk(H);
            exp_q.push_back(hit ? {1'b1, v[k]} : 2'b00);
            tag_q.push_back(t);
            sck_r = 1'b1;
            wait_clk(H);
            sck_r = 1'b0;
        end
        wait_clk(H);
        cs_n_r = 1'b1;
        wait_clk(4);
        check({miso_oe, miso}, 2'b00, "R7 deselect");
        wait_clk(H);
    endtask

    initial begin
        wait_clk(3);
        check({miso_oe, miso}, 2'b00, "R1 in reset");
        rst_n = 1'b1;
        wait_clk(4);
        check({miso_oe, miso}, 2'b00, "R1 after reset");

        xfer(8'h9F, 8, 1'b1, 6 * 8, "");      // R3 R4 R5 R9
        xfer(8'h03, 8, 1'b0, 3 * 8, "");      // R6 unrelated command
        xfer(8'h9E, 8, 1'b0, 2 * 8, "");      // R6 one-bit difference
        xfer(8'h9F, 8, 1'b1, 13, "");         // R7 abort mid device byte
        xfer(8'h9F, 8, 1'b1, 8, "R7 restart");
        xfer(8'h9F, 4, 1'b0, 0, "");          // R7 abort mid command
        xfer(8'h9F, 8, 1'b1, 16, "R7 after short");

        wait_clk(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule